// File: doc/BRIEF.md
# Reset Stretch and Boot-Strap Sequencer

This block turns a raw, active-low board reset into the reset sequence a processor core and its pads rely on. A board reset going low takes effect at once, with no clock needed. The internal reset drops. The output enables for the external memory bus and for the two general pin groups drop too. The outgoing bus request is forced inactive. Two clock outputs are floated, and a third clock output is driven low.

When the board reset is released, the release first passes through a two-flop synchronizer in the reference clock domain. A counter then holds the internal reset for a fixed number of reference cycles. During that whole interval the core clock enable pulses only once every eight reference cycles, so the core runs at one eighth of the reference rate. On the rising edge of the synchronized release, four strap bits are captured from the 16-bit host data bus and held until the next reset. On the release cycle itself, the internal reset and the done flag go high, and all pin groups and clock outputs come back. The PLL-bypass flag leaves reset set, and software may later change it through a one-bit write port.

Top module: `rstseq_top`

## Requirements
- R1: With `STRETCH_CYC`=512, `int_rst_n` is still 0 after 513 rising clock edges following the rise of `ext_rst_n`, and is 1 after the 514th. That is 2 synchronizer edges plus 512 counted edges.
- R2: A fall of `ext_rst_n` drives `int_rst_n` and `rst_done` to 0 without waiting for a clock edge.
- R3: While `int_rst_n` is 0, `core_clk_en` is 1 on exactly one cycle in every 8 consecutive cycles. Once `int_rst_n` is 1, it is 1 on every cycle.
- R4: On the third rising edge after the rise of `ext_rst_n`, `boot_cfg` is loaded with host data bits {14, 8, 4, 3}. Bit 14 lands in `boot_cfg[3]` and bit 3 lands in `boot_cfg[0]`.
- R5: Once captured, `boot_cfg` keeps its value while reset stays released, whatever `host_data` does.
- R6: All three bits of `pin_oe` are 0, and `busreq` is 0, from the fall of `ext_rst_n` with no clock. On the cycle `int_rst_n` rises, `pin_oe` becomes 3'b111 and `busreq` follows `core_busreq`.
- R7: While in reset, `clkout_a_oe` and `clkout_b_oe` are 0 (high impedance) and `clkout_c_force_low` is 1. All three change state on the release cycle, which is well within six core periods.
- R8: `pll_bypass` is 1 when `int_rst_n` rises. After release, a cycle with `cfg_we`=1 loads `cfg_wdata` into `pll_bypass` at the next edge. Writes made while in reset are ignored.
- R9: If `ext_rst_n` falls during the stretch interval, the count restarts from zero. The next release again takes 514 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| ext_rst_n | input | 1 | Asynchronous active-low board reset |
| host_data | input | 16 | Host data bus carrying boot straps |
| core_busreq | input | 1 | Bus request from the core side |
| cfg_we | input | 1 | Write strobe for the PLL-bypass control bit |
| cfg_wdata | input | 1 | Value written into the PLL-bypass control bit |
| int_rst_n | output | 1 | Stretched internal reset, active low |
| rst_done | output | 1 | High once the reset sequence has completed |
| core_clk_en | output | 1 | Core clock enable (1 of 8 in reset, always after) |
| boot_cfg | output | 4 | Captured straps {d14, d8, d4, d3} |
| pin_oe | output | 3 | Output enables {memory bus, group 1, group 2} |
| busreq | output | 1 | Bus request output, inactive (0) in reset |
| clkout_a_oe | output | 1 | Output enable of clock output A |
| clkout_b_oe | output | 1 | Output enable of clock output B |
| clkout_c_force_low | output | 1 | Forces clock output C low |
| pll_bypass | output | 1 | PLL bypass control, set on reset |

## Verification
A counter that is off by one in the stretch shows as `int_rst_n` rising one edge early or late. That is visible on the exact edge the bench samples. A divider phase error shows within one eight-cycle window as a wrong pulse count on `core_clk_en`. A strap capture taken on the wrong edge, or taken again later, shows as a wrong `boot_cfg` three edges after release or at the end of the stretch, once the bench has inverted `host_data`. A missed async path shows within two nanoseconds of `ext_rst_n` falling, before any clock edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int STRAP_W = 16;
    localparam int CFG_W   = 4;

    // Captured boot straps, most significant selected bit first
    typedef struct packed {
        logic s14;
        logic s8;
        logic s4;
        logic s3;
    } boot_cfg_t;

    // Pin group output enables
    typedef struct packed {
        logic mem_bus;
        logic grp1;
        logic grp2;
    } pin_oe_t;

    function automatic boot_cfg_t pick_straps(input logic [STRAP_W-1:0] d);
        boot_cfg_t c;
        c.s14 = d[14];
        c.s8  = d[8];
        c.s4  = d[4];
        c.s3  = d[3];
        return c;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync (
    input  logic clk,
    input  logic arst_n,
    output logic rel_o
);
    logic ff1, ff2;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ff1 <= 1'b0;
            ff2 <= 1'b0;
        end else begin
            ff1 <= 1'b1;
            ff2 <= ff1;
        end
    end

    assign rel_o = ff2;
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
    parameter int STRETCH_CYC = 512,
    parameter int CORE_DIV    = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rel_i,
    output logic done_o,
    output logic core_en_o
);
    localparam int CNT_W = (STRETCH_CYC > 2) ? $clog2(STRETCH_CYC) : 1;
    localparam int DIV_W = (CORE_DIV > 2) ? $clog2(CORE_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(STRETCH_CYC - 1);
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(CORE_DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div;
    logic             done;

    // Stretch counter: starts after synchronized release, cleared on any reset
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (rel_i && !done) begin
            if (cnt == LAST) done <= 1'b1;
            else             cnt  <= cnt + 1'b1;
        end
    end

    // Free-running divider for the slow core clock during reset
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) div <= '0;
        else         div <= div + 1'b1;
    end

    assign done_o    = done;
    assign core_en_o = done | (div == DIV_TOP);

    // R1
    stretch_len_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(done) |-> ($past(cnt) == LAST) && $past(rel_i));

    // R3
    div_gap_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!done && core_en_o) |=> !core_en_o);
endmodule

// File: rtl/rstseq_strap.sv
module rstseq_strap
    import rstseq_pkg::*;
(
    input  logic               clk,
    input  logic               arst_n,
    input  logic               rel_i,
    input  logic [STRAP_W-1:0] host_data_i,
    output boot_cfg_t          cfg_o
);
    logic      rel_q;
    boot_cfg_t cfg_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rel_q <= 1'b0;
            cfg_q <= '0;
        end else begin
            rel_q <= rel_i;
            if (rel_i && !rel_q) cfg_q <= pick_straps(host_data_i);
        end
    end

    assign cfg_o = cfg_q;

    // R5
    strap_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        rel_q |=> $stable(cfg_q));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int STRETCH_CYC = 512,
    parameter int CORE_DIV    = 8
) (
    input  logic                clk,
    input  logic                ext_rst_n,
    input  logic [STRAP_W-1:0]  host_data,
    input  logic                core_busreq,
    input  logic                cfg_we,
    input  logic                cfg_wdata,
    output logic                int_rst_n,
    output logic                rst_done,
    output logic                core_clk_en,
    output logic [CFG_W-1:0]    boot_cfg,
    output logic [2:0]          pin_oe,
    output logic                busreq,
    output logic                clkout_a_oe,
    output logic                clkout_b_oe,
    output logic                clkout_c_force_low,
    output logic                pll_bypass
);
    logic      rel;
    logic      done;
    boot_cfg_t cfg;
    pin_oe_t   oe;
    logic      bypass_q;

    rstseq_sync u_sync (
        .clk    (clk),
        .arst_n (ext_rst_n),
        .rel_o  (rel)
    );

    rstseq_stretch #(
        .STRETCH_CYC (STRETCH_CYC),
        .CORE_DIV    (CORE_DIV)
    ) u_stretch (
        .clk       (clk),
        .arst_n    (ext_rst_n),
        .rel_i     (rel),
        .done_o    (done),
        .core_en_o (core_clk_en)
    );

    rstseq_strap u_strap (
        .clk         (clk),
        .arst_n      (ext_rst_n),
        .rel_i       (rel),
        .host_data_i (host_data),
        .cfg_o       (cfg)
    );

    // PLL bypass control: set by reset, writable only after release
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)         bypass_q <= 1'b1;
        else if (cfg_we && done) bypass_q <= cfg_wdata;
    end

    always_comb begin
        oe.mem_bus = done;
        oe.grp1    = done;
        oe.grp2    = done;
    end

    assign int_rst_n          = done;
    assign rst_done           = done;
    assign boot_cfg           = cfg;
    assign pin_oe             = oe;
    assign busreq             = core_busreq & done;
    assign clkout_a_oe        = done;
    assign clkout_b_oe        = done;
    assign clkout_c_force_low = ~done;
    assign pll_bypass         = bypass_q;

    // R8
    pll_bypass_rel_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(done) |-> bypass_q);
endmodule

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;
    logic        clk = 1'b0;
    logic        ext_rst_n = 1'b0;
    logic [15:0] host_data = 16'h0000;
    logic        core_busreq = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_wdata = 1'b0;
    logic        int_rst_n, rst_done, core_clk_en, busreq;
    logic        clkout_a_oe, clkout_b_oe, clkout_c_force_low, pll_bypass;
    logic [3:0]  boot_cfg;
    logic [2:0]  pin_oe;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rstseq_top u_dut (
        .clk(clk), .ext_rst_n(ext_rst_n), .host_data(host_data),
        .core_busreq(core_busreq), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .int_rst_n(int_rst_n), .rst_done(rst_done), .core_clk_en(core_clk_en),
        .boot_cfg(boot_cfg), .pin_oe(pin_oe), .busreq(busreq),
        .clkout_a_oe(clkout_a_oe), .clkout_b_oe(clkout_b_oe),
        .clkout_c_force_low(clkout_c_force_low), .pll_bypass(pll_bypass)
    );

    // {host data, expected straps {d14,d8,d4,d3}}
    localparam logic [19:0] VEC [6] = '{
        {16'h4118, 4'hF}, {16'h0000, 4'h0}, {16'hBEE7, 4'h0},
        {16'h4000, 4'h8}, {16'h0008, 4'h1}, {16'h0110, 4'h6}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Ends on the negedge at which ext_rst_n rises
    task automatic release_seq(input logic [15:0] d);
        @(negedge clk);
        ext_rst_n = 1'b0;
        host_data = d;
        repeat (20) @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int en_cnt;
        repeat (5) @(negedge clk);
        chk("R2 reset int_rst_n", int_rst_n, 0);
        chk("R6 reset pin_oe", pin_oe, 0);
        chk("R6 reset busreq", busreq, 0);
        chk("R7 reset clkout_a_oe", clkout_a_oe, 0);
        chk("R7 reset clkout_c_force_low", clkout_c_force_low, 1);
        chk("R8 reset pll_bypass", pll_bypass, 1);

        // Vector table: strap capture, hold and stretch length
        for (int i = 0; i < 6; i++) begin
            release_seq(VEC[i][19:4]);
            repeat (3) @(negedge clk);
            chk("R4 strap capture", boot_cfg, VEC[i][3:0]);
            host_data = ~VEC[i][19:4];
            repeat (510) @(negedge clk);
            chk("R1 still in reset at 513", int_rst_n, 0);
            chk("R7 clkout_b_oe in reset", clkout_b_oe, 0);
            @(negedge clk);
            chk("R1 released at 514", int_rst_n, 1);
            chk("R6 pin_oe restored", pin_oe, 3'b111);
            chk("R7 clkout valid", {clkout_a_oe, clkout_b_oe, clkout_c_force_low}, 3'b110);
            chk("R5 strap held", boot_cfg, VEC[i][3:0]);
            repeat (4) @(negedge clk);
            chk("R5 strap still held", boot_cfg, VEC[i][3:0]);
        end

        // R6: bus request follows the core after release
        core_busreq = 1'b1;
        @(negedge clk);
        chk("R6 busreq follows", busreq, 1);

        // R2: asynchronous assertion between clock edges
        #1 ext_rst_n = 1'b0;
        #1;
        chk("R2 async int_rst_n", int_rst_n, 0);
        chk("R2 async rst_done", rst_done, 0);
        chk("R6 async pin_oe", pin_oe, 0);
        chk("R6 async busreq", busreq, 0);
        chk("R7 async clkout_c_force_low", clkout_c_force_low, 1);

        // R3: slow core enable during stretch, full rate after
        release_seq(16'h0000);
        repeat (10) @(negedge clk);
        en_cnt = 0;
        for (int k = 0; k < 64; k++) begin
            if (core_clk_en) en_cnt++;
            @(negedge clk);
        end
        chk("R3 enables per 64 in reset", en_cnt, 8);
        repeat (440) @(negedge clk);
        en_cnt = 0;
        for (int k = 0; k < 16; k++) begin
            if (core_clk_en) en_cnt++;
            @(negedge clk);
        end
        chk("R3 enables per 16 after release", en_cnt, 16);

        // R8: bypass writable after release
        chk("R8 bypass at release", pll_bypass, 1);
        cfg_we = 1'b1; cfg_wdata = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R8 bypass cleared by write", pll_bypass, 0);

        // R8: writes during reset ignored
        release_seq(16'h0000);
        cfg_we = 1'b1; cfg_wdata = 1'b0;
        repeat (513) @(negedge clk);
        chk("R8 bypass held during reset writes", pll_bypass, 1);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R8 bypass set at release", pll_bypass, 1);

        // R9: reassertion mid-stretch restarts the count
        release_seq(16'h0000);
        repeat (300) @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (20) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (513) @(negedge clk);
        chk("R9 restart still in reset", int_rst_n, 0);
        @(negedge clk);
        chk("R9 restart released", int_rst_n, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule